// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps the contents of an SDRAM alive while an access sequencer handles reads and writes. An internal interval timer decides when the next auto refresh is due. The manager then raises a request to the sequencer. Once the sequencer grants the command bus, the manager issues the refresh and keeps ownership of the bus until the refresh cycle time has passed. During refresh the device generates the row and bank addresses itself, so this block drives no address.

A host sleep request moves the memory into self-refresh. The manager claims the bus, issues the self-refresh command and drops the clock-enable line in the same cycle. It keeps the line low for at least the minimum hold time, even if the sleep request is withdrawn sooner. On exit it raises clock-enable and drives NOPs for a fixed exit window and then one refresh cycle time. After that it issues one auto refresh for every row, back to back, because the device cannot report which row it refreshed last. Normal access resumes only when this catch-up burst is complete. The refresh interval is computed from the clock frequency, the retention window, the row count and a safety margin.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: While reset is applied and in the first cycle after it, `cke_o` is 1, `cmd_o` is NOP (2'b00), `ref_req_o` is 0 and `bus_own_o` is 0.
- R2: The interval is INTERVAL = floor(WINDOW_US*CLK_MHZ/ROWS) - MARGIN cycles. While `ref_gnt_i` stays high, consecutive periodic auto refresh commands (`cmd_o` = 2'b01) are exactly INTERVAL cycles apart.
- R3: A refresh that is due holds `ref_req_o` high, with `cmd_o` at NOP and `bus_own_o` low, for as long as `ref_gnt_i` is low. The auto refresh appears in the cycle after the first clock edge at which the grant is sampled high.
- R4: For the TRC_CYC-1 cycles after each auto refresh, `bus_own_o` is 1 and `cmd_o` is NOP. TRC_CYC cycles after the command, `bus_own_o` is 0 if nothing else is due.
- R5: When `sleep_req_i` is high and nothing is outstanding, the manager requests the bus. On grant it issues the self-refresh entry command (`cmd_o` = 2'b10) with `cke_o` low in that same cycle.
- R6: `cke_o` stays low for at least TRAS_CYC cycles, counting the entry cycle, even if `sleep_req_i` drops earlier. If sleep has already been withdrawn, `cke_o` returns high exactly TRAS_CYC cycles after entry.
- R7: After `cke_o` rises, `cmd_o` is NOP for EXIT_NOPS + TRC_CYC cycles with `bus_own_o` held. The first catch-up auto refresh follows directly.
- R8: The catch-up burst is ROWS auto refresh commands spaced TRC_CYC apart, with `bus_own_o` high throughout. The bus is released TRC_CYC cycles after the last command of the burst.
- R9: A sleep request that arrives while a refresh is due but not yet granted is deferred. The auto refresh is issued first, and the self-refresh entry follows TRC_CYC + 2 cycles later.
- R10: If `sleep_req_i` drops before the bus is granted for self-refresh, the request is withdrawn, no self-refresh entry is issued and `cke_o` stays high.
- R11: After the catch-up burst the interval timer restarts. The next periodic auto refresh comes TRC_CYC + INTERVAL + 2 cycles after the last catch-up command when the grant is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req_i | input | 1 | Host request to enter and stay in self-refresh |
| ref_gnt_i | input | 1 | Sequencer grant: command bus is idle and handed over |
| ref_req_o | output | 1 | Manager wants the command bus |
| bus_own_o | output | 1 | Manager owns the command bus; sequencer must stay off |
| cke_o | output | 1 | SDRAM clock-enable |
| cmd_o | output | 2 | Command: 00 NOP, 01 auto refresh, 10 self-refresh entry |

## Verification
The bench holds the grant low across a due refresh. A manager that does not keep the request pending would drop the refresh or issue it without owning the bus. The bench raises sleep while that refresh is still outstanding, so a design without deferral would enter self-refresh with the refresh skipped or would cut short its recovery gap. It also withdraws sleep right after entry, which exposes a manager that releases clock-enable before the minimum hold time. The catch-up burst is counted and timed from the clock-enable edge: one refresh too few, or a missing exit NOP window, shows up as a wrong command gap. The first periodic refresh after the burst is timed as well, which catches a timer that kept running or was not reloaded.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_AREF = 2'b01,
    CMD_SREF = 2'b10
  } ref_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ_AREF,
    ST_ISSUE_AREF,
    ST_TRC_WAIT,
    ST_REQ_SREF,
    ST_SREF_ENTER,
    ST_SREF_HOLD,
    ST_EXIT_NOP,
    ST_EXIT_TRC,
    ST_CU_ISSUE,
    ST_CU_WAIT
  } ref_state_e;

  // Cycles between periodic refreshes: share of the retention window per row, less margin.
  function automatic int unsigned interval_cycles(input int unsigned clk_mhz,
                                                  input int unsigned window_us,
                                                  input int unsigned rows,
                                                  input int unsigned margin);
    int unsigned raw;
    raw = (clk_mhz * window_us) / rows;
    return (raw > margin + 1) ? raw - margin : 2;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL = 3890
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic reload_i,
  input  logic serve_i,
  output logic due_o,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          due_q;

  assign expire_o = run_i && (cnt_q == '0);
  assign due_o    = due_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      due_q <= 1'b0;
    end else begin
      if (reload_i) begin
        cnt_q <= RELOAD;
      end else if (run_i) begin
        cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
      end
      if (reload_i)      due_q <= 1'b0;
      else if (expire_o) due_q <= 1'b1;
      else if (serve_i)  due_q <= 1'b0;
    end
  end

  // R2
  due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (due_o && !serve_i && !reload_i) |=> due_o);

endmodule

// File: rtl/ref_wait_timer.sv
module ref_wait_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // R4
  wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ref_burst_counter.sv
module ref_burst_counter #(
  parameter int unsigned ROWS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic dec_i,
  output logic empty_o
);
  generate
    if (ROWS == 1) begin : g_single
      logic left_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= 1'b0;
        else if (load_i) left_q <= 1'b1;
        else if (dec_i)  left_q <= 1'b0;
      end
      assign empty_o = !left_q;
    end else begin : g_count
      localparam int unsigned BW = $clog2(ROWS + 1);
      logic [BW-1:0] left_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= '0;
        else if (load_i) left_q <= BW'(ROWS);
        else if (dec_i)  left_q <= left_q - 1'b1;
      end
      assign empty_o = (left_q == '0);
    end
  endgenerate

  // R8
  burst_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> !empty_o);

endmodule

// File: rtl/ref_ctrl_fsm.sv
module ref_ctrl_fsm
  import sdram_ref_pkg::*;
#(
  parameter int unsigned TRC_CYC   = 9,
  parameter int unsigned TRAS_CYC  = 11,
  parameter int unsigned EXIT_NOPS = 2,
  parameter int unsigned WW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req_i,
  input  logic          ref_gnt_i,
  input  logic          due_i,
  input  logic          wait_done_i,
  input  logic          burst_empty_i,
  output logic          ref_req_o,
  output logic          bus_own_o,
  output logic          cke_o,
  output ref_cmd_e      cmd_o,
  output logic          timer_run_o,
  output logic          timer_serve_o,
  output logic          timer_reload_o,
  output logic          wait_load_o,
  output logic [WW-1:0] wait_val_o,
  output logic          burst_load_o,
  output logic          burst_dec_o
);
  localparam logic [WW-1:0] LD_GAP  = WW'(TRC_CYC - 2);
  localparam logic [WW-1:0] LD_HOLD = WW'(TRAS_CYC - 2);
  localparam logic [WW-1:0] LD_NOPS = WW'(EXIT_NOPS - 1);
  localparam logic [WW-1:0] LD_RCV  = WW'(TRC_CYC - 1);

  ref_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d        = state_q;
    wait_load_o    = 1'b0;
    wait_val_o     = '0;
    burst_load_o   = 1'b0;
    burst_dec_o    = 1'b0;
    timer_reload_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (due_i)            state_d = ST_REQ_AREF;
        else if (sleep_req_i) state_d = ST_REQ_SREF;
      end
      ST_REQ_AREF: if (ref_gnt_i) state_d = ST_ISSUE_AREF;
      ST_ISSUE_AREF: begin
        state_d     = ST_TRC_WAIT;
        wait_load_o = 1'b1;
        wait_val_o  = LD_GAP;
      end
      ST_TRC_WAIT: if (wait_done_i) state_d = ST_IDLE;
      ST_REQ_SREF: begin
        if (!sleep_req_i)   state_d = ST_IDLE;
        else if (ref_gnt_i) state_d = ST_SREF_ENTER;
      end
      ST_SREF_ENTER: begin
        state_d     = ST_SREF_HOLD;
        wait_load_o = 1'b1;
        wait_val_o  = LD_HOLD;
      end
      ST_SREF_HOLD: begin
        if (wait_done_i && !sleep_req_i) begin
          state_d      = ST_EXIT_NOP;
          wait_load_o  = 1'b1;
          wait_val_o   = LD_NOPS;
          burst_load_o = 1'b1;
        end
      end
      ST_EXIT_NOP: begin
        if (wait_done_i) begin
          state_d     = ST_EXIT_TRC;
          wait_load_o = 1'b1;
          wait_val_o  = LD_RCV;
        end
      end
      ST_EXIT_TRC: if (wait_done_i) state_d = ST_CU_ISSUE;
      ST_CU_ISSUE: begin
        state_d     = ST_CU_WAIT;
        wait_load_o = 1'b1;
        wait_val_o  = LD_GAP;
        burst_dec_o = 1'b1;
      end
      ST_CU_WAIT: begin
        if (wait_done_i) begin
          if (burst_empty_i) begin
            state_d        = ST_IDLE;
            timer_reload_o = 1'b1;
          end else begin
            state_d = ST_CU_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ref_req_o     = (state_q == ST_REQ_AREF) || (state_q == ST_REQ_SREF);
    cke_o         = !((state_q == ST_SREF_ENTER) || (state_q == ST_SREF_HOLD));
    bus_own_o     = !((state_q == ST_IDLE) || ref_req_o);
    timer_run_o   = (state_q == ST_IDLE) || (state_q == ST_REQ_AREF) ||
                    (state_q == ST_ISSUE_AREF) || (state_q == ST_TRC_WAIT) ||
                    (state_q == ST_REQ_SREF);
    timer_serve_o = (state_q == ST_ISSUE_AREF) || (state_q == ST_SREF_ENTER);
    case (state_q)
      ST_ISSUE_AREF, ST_CU_ISSUE: cmd_o = CMD_AREF;
      ST_SREF_ENTER:              cmd_o = CMD_SREF;
      default:                    cmd_o = CMD_NOP;
    endcase
  end

  // R3
  pending_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && !ref_gnt_i) |=> (cmd_o == CMD_NOP));

  // R4
  aref_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_AREF) |=> (cmd_o == CMD_NOP && bus_own_o));

  // R5
  sref_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_SREF) |-> !cke_o);

  // R7
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> (cmd_o == CMD_NOP && bus_own_o));

endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
  import sdram_ref_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 250,
  parameter int unsigned WINDOW_US = 64000,
  parameter int unsigned ROWS      = 4096,
  parameter int unsigned MARGIN    = 16,
  parameter int unsigned TRC_CYC   = 17,
  parameter int unsigned TRAS_CYC  = 11,
  parameter int unsigned EXIT_NOPS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req_i,
  input  logic       ref_gnt_i,
  output logic       ref_req_o,
  output logic       bus_own_o,
  output logic       cke_o,
  output logic [1:0] cmd_o
);
  localparam int unsigned INTERVAL = interval_cycles(CLK_MHZ, WINDOW_US, ROWS, MARGIN);
  localparam int unsigned WW       = $clog2(max3(TRC_CYC, TRAS_CYC, EXIT_NOPS) + 1);
  localparam int unsigned LW       = $clog2(TRAS_CYC + 2);

  logic          due, expire;
  logic          wait_done, burst_empty;
  logic          timer_run, timer_serve, timer_reload;
  logic          wait_load, burst_load, burst_dec;
  logic [WW-1:0] wait_val;
  ref_cmd_e      cmd;

  // Named events for the properties below.
  logic aref_issue, sref_entry;
  assign aref_issue = (cmd == CMD_AREF);
  assign sref_entry = (cmd == CMD_SREF);
  assign cmd_o      = cmd;

  ref_interval_timer #(.INTERVAL(INTERVAL)) u_interval (
    .clk(clk), .rst_n(rst_n), .run_i(timer_run), .reload_i(timer_reload),
    .serve_i(timer_serve), .due_o(due), .expire_o(expire)
  );

  ref_wait_timer #(.W(WW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load_i(wait_load), .load_val_i(wait_val),
    .done_o(wait_done)
  );

  ref_burst_counter #(.ROWS(ROWS)) u_burst (
    .clk(clk), .rst_n(rst_n), .load_i(burst_load), .dec_i(burst_dec),
    .empty_o(burst_empty)
  );

  ref_ctrl_fsm #(
    .TRC_CYC(TRC_CYC), .TRAS_CYC(TRAS_CYC), .EXIT_NOPS(EXIT_NOPS), .WW(WW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .ref_gnt_i(ref_gnt_i),
    .due_i(due), .wait_done_i(wait_done), .burst_empty_i(burst_empty),
    .ref_req_o(ref_req_o), .bus_own_o(bus_own_o), .cke_o(cke_o), .cmd_o(cmd),
    .timer_run_o(timer_run), .timer_serve_o(timer_serve),
    .timer_reload_o(timer_reload), .wait_load_o(wait_load), .wait_val_o(wait_val),
    .burst_load_o(burst_load), .burst_dec_o(burst_dec)
  );

  // Low-time counter used only by the hold-time property.
  logic [LW-1:0] low_cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                        low_cnt_q <= '0;
    else if (cke_o)                    low_cnt_q <= '0;
    else if (low_cnt_q != LW'(TRAS_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  // R6
  tras_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> (low_cnt_q == LW'(TRAS_CYC)));

  // R5
  sref_from_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sref_entry |-> ($past(ref_gnt_i) && $past(ref_req_o)));

  // R2
  expire_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> cke_o);

  // R8
  aref_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aref_issue |-> (bus_own_o && cke_o));

endmodule

// File: tb/sdram_refresh_mgr_tb.sv
module sdram_refresh_mgr_tb_top;
  localparam int T_MHZ    = 250;
  localparam int T_WIN    = 1;
  localparam int T_ROWS   = 4;
  localparam int T_MARGIN = 2;
  localparam int T_RC     = 5;
  localparam int T_RAS    = 12;
  localparam int T_NOPS   = 2;
  // 250 clocks per microsecond over 4 rows: 62 per row, less the margin.
  localparam int EXP_INTV = (T_WIN * T_MHZ) / T_ROWS - T_MARGIN;

  localparam logic [1:0] C_NOP  = 2'b00;
  localparam logic [1:0] C_AREF = 2'b01;
  localparam logic [1:0] C_SREF = 2'b10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, sleep_req, ref_gnt;
  logic       ref_req, bus_own, cke;
  logic [1:0] cmd;

  sdram_refresh_mgr #(
    .CLK_MHZ(T_MHZ), .WINDOW_US(T_WIN), .ROWS(T_ROWS), .MARGIN(T_MARGIN),
    .TRC_CYC(T_RC), .TRAS_CYC(T_RAS), .EXIT_NOPS(T_NOPS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .ref_gnt_i(ref_gnt),
    .ref_req_o(ref_req), .bus_own_o(bus_own), .cke_o(cke), .cmd_o(cmd)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [1:0] c;
    int         gmin;
    int         gmax;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input int gmin, input int gmax, input string tag);
    exp_t e;
    e.c = c; e.gmin = gmin; e.gmax = gmax; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  // Monitor: every non-NOP command is compared with the next expected item.
  always @(negedge clk) begin
    if (rst_n && cmd != C_NOP) begin
      int   gap;
      exp_t e;
      gap = cyc - last_cyc;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(cmd == e.c, e.tag, "command code", int'(cmd), int'(e.c));
        check(gap >= e.gmin && gap <= e.gmax, e.tag, "command gap", gap, e.gmin);
      end else if (cmd != C_AREF) begin
        check(1'b0, "R10", "unexpected command", int'(cmd), int'(C_AREF));
      end
      if (cmd == C_SREF) check(cke == 1'b0, "R5", "cke at entry", int'(cke), 0);
      last_cyc = cyc;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int bad;
    int lowcnt;
    int gcyc;
    rst_n = 1'b0; sleep_req = 1'b0; ref_gnt = 1'b1;
    repeat (5) tick();
    smp();
    check(cke == 1'b1 && cmd == C_NOP, "R1", "cke/cmd in reset", int'({cke, cmd}), 4);
    tick();
    rst_n = 1'b1;
    smp();
    check(cke == 1'b1, "R1", "cke after reset", int'(cke), 1);
    check(cmd == C_NOP, "R1", "cmd after reset", int'(cmd), 0);
    check(ref_req == 1'b0, "R1", "ref_req after reset", int'(ref_req), 0);
    check(bus_own == 1'b0, "R1", "bus_own after reset", int'(bus_own), 0);

    // R2: periodic refresh spacing with the grant held high.
    push(C_AREF, 0, 1000, "R2");
    for (int i = 0; i < 3; i++) push(C_AREF, EXP_INTV, EXP_INTV, "R2");
    wait (q.size() == 0);

    // R3: grant withheld across a due refresh.
    tick();
    ref_gnt = 1'b0;
    while (!ref_req) smp();
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      smp();
      if (cmd != C_NOP || bus_own || !ref_req) bad++;
    end
    check(bad == 0, "R3", "quiet while waiting for grant", bad, 0);
    push(C_AREF, EXP_INTV, EXP_INTV + 40, "R3");
    tick();
    ref_gnt = 1'b1;
    gcyc = cyc;
    wait (q.size() == 0);
    check(last_cyc == gcyc + 1, "R3", "refresh cycle after grant", last_cyc, gcyc + 1);

    // R4: recovery window after the refresh.
    bad = 0;
    for (int i = 1; i < T_RC; i++) begin
      smp();
      if (!bus_own || cmd != C_NOP) bad++;
    end
    check(bad == 0, "R4", "bus held with NOP during tRC", bad, 0);
    smp();
    check(bus_own == 1'b0, "R4", "bus released after tRC", int'(bus_own), 0);

    // R9: sleep arrives while a refresh is outstanding.
    tick();
    ref_gnt = 1'b0;
    while (!ref_req) smp();
    tick();
    sleep_req = 1'b1;
    repeat (8) tick();
    push(C_AREF, 0, 1000, "R9");
    push(C_SREF, T_RC + 2, T_RC + 2, "R9");
    ref_gnt = 1'b1;
    wait (q.size() == 0);

    // R7, R8, R11: exit timing, catch-up burst, timer restart.
    push(C_AREF, T_RAS + T_NOPS + T_RC, T_RAS + T_NOPS + T_RC, "R7");
    for (int i = 1; i < T_ROWS; i++) push(C_AREF, T_RC, T_RC, "R8");
    push(C_AREF, T_RC + EXP_INTV + 2, T_RC + EXP_INTV + 2, "R11");

    // R6: sleep dropped at once; the hold time must still be met.
    tick();
    sleep_req = 1'b0;
    lowcnt = 1;
    for (int i = 0; i < 100; i++) begin
      smp();
      if (cke) break;
      lowcnt++;
    end
    check(lowcnt == T_RAS, "R6", "cke low cycles", lowcnt, T_RAS);

    bad = bus_own ? 0 : 1;
    for (int i = 1; i < T_NOPS + T_RC + T_ROWS * T_RC; i++) begin
      smp();
      if (!bus_own) bad++;
    end
    check(bad == 0, "R8", "bus held through exit and catch-up", bad, 0);
    smp();
    check(bus_own == 1'b0, "R8", "bus released after catch-up", int'(bus_own), 0);
    wait (q.size() == 0);

    // R10: sleep withdrawn before the grant.
    repeat (T_RC + 3) tick();
    ref_gnt = 1'b0;
    sleep_req = 1'b1;
    repeat (4) smp();
    check(ref_req == 1'b1, "R10", "request raised for sleep", int'(ref_req), 1);
    tick();
    sleep_req = 1'b0;
    repeat (2) smp();
    check(ref_req == 1'b0, "R10", "request withdrawn", int'(ref_req), 0);
    check(cke == 1'b1, "R10", "cke stays high", int'(cke), 1);
    tick();
    ref_gnt = 1'b1;
    push(C_AREF, 0, 1000, "R10");
    wait (q.size() == 0);
    repeat (4) tick();
    finish_run();
  end

endmodule